// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous Memory

This block is a single-port synchronous memory that accepts one command per clock, read or write in any mix, and never inserts an idle cycle when the traffic turns from reads to writes or back. Every input is captured on the rising clock edge. Read data comes out of a register, and write data follows its address two enabled clock edges later. The command register and two write-address stages hold each write's address and byte mask until its data arrives. A read that targets a word whose write is still in those stages gets the pending bytes merged over the stored word, with the newest write taking priority.

Commands start through a load cycle. Each load sets a new base address and picks the burst order. Advance cycles then step through the other three words of the aligned four-word group, in linear or interleaved order. A clock-enable input freezes the whole pipeline. Three chip-select inputs gate new loads. The read-data bus is given as separate data, valid and drive-enable outputs. The drive enable is switched off on every cycle that belongs to a write's data transfer, and it is also gated by an asynchronous output-enable input.

Top module: `zt_sram`

## Requirements
- R1: A read captured at an enabled edge presents its word on `rdata` with `rd_valid` high right after the next enabled edge. The word then holds until another enabled edge.
- R2: A write changes only the bytes whose `be` bit is 1. Bit i covers `wdata[8i+7:8i]`. The other bytes keep their stored value.
- R3: A read returns every write captured at earlier enabled edges, even when that write's data has not reached the array yet. Byte by byte, the newest pending write wins.
- R4: Reads and writes can be issued on every enabled cycle in any order, with no wait cycles, and each read still returns correct data.
- R5: While `clk_en` is 0, clock edges change no state. `rdata`, `rd_valid` and `rdata_oe` keep their values, and a pending write's data is expected on the first enabled edge that follows.
- R6: A load cycle is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect: after the next enabled edge, `rd_valid` is 0.
- R7: On the cycle in which a write's data is on `wdata`, that is after the first enabled edge following the write's capture, `rd_valid` and `rdata_oe` are 0.
- R8: `rdata_oe` is 1 only when `rd_valid` is 1 and `out_en` is 1. It follows `out_en` with no clock involved.
- R9: `adv`=0 loads `addr` as the burst base. Each following `adv`=1 cycle steps the index 1,2,3,0,... In linear order (`interleave`=0 at load time) the low two address bits are base+index modulo 4. The upper bits stay at the base value.
- R10: With `interleave`=1 at load time, the low two address bits of an advance are the base low bits XOR the index.
- R11: An advance cycle repeats the type of the last load (read, write or deselect), whatever `wr` and the chip selects show during it. `be` is sampled on every cycle.
- R12: While `rst_n` is 0 at a clock edge, `rd_valid` and `rdata_oe` are 0 after that edge, even if `clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock qualifier; 0 freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load new command, 1 = advance burst |
| wr | input | 1 | On a load: 1 = write, 0 = read |
| be | input | BYTES | Byte write mask, bit i covers byte i |
| interleave | input | 1 | Burst order on a load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address on a load |
| wdata | input | BYTES*BYTE_W | Write data, two enabled edges after its command |
| out_en | input | 1 | Asynchronous output drive enable |
| rdata | output | BYTES*BYTE_W | Registered read data |
| rd_valid | output | 1 | rdata carries a read result |
| rdata_oe | output | 1 | Drive enable for the read-data bus |

## Verification
The checker follows the command type at each enabled edge. On every cycle it checks that `rd_valid` is high exactly one enabled edge after a read and low after a write or a deselect, which keeps the bus undriven during write data phases. It also checks that a stall freezes the outputs, that `rdata_oe` never asserts without both `out_en` and `rd_valid`, and that reset clears the drive. Whether the word returned is right depends on the history of addresses, masks and pending writes, so only the bench scenarios can show it: byte merges, forwarding from either write stage, newest-wins overlap, both burst orders and random mixed traffic compared against a reference memory.

// File: rtl/zt_pkg.sv
`timescale 1ns/1ps
package zt_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } zt_op_e;

   // low two address bits of a burst beat
   function automatic logic [1:0] burst_low(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       ilv);
      return ilv ? (start ^ step) : (start + step);
   endfunction

endpackage

// File: rtl/zt_burst_addr.sv
`timescale 1ns/1ps
module zt_burst_addr
   import zt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              adv,
   input  logic              selected,
   input  logic              wr,
   input  logic              ilv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTES-1:0]  be,
   output zt_op_e            op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [BYTES-1:0]  cmd_be
);

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        idx_q;
   logic [1:0]        idx_nx;
   zt_op_e            last_op_q;
   logic              ilv_q;

   assign idx_nx = idx_q + 2'd1;
   assign cmd_be = be;

   always_comb begin
      if (!adv) begin
         op       = selected ? (wr ? OP_WRITE : OP_READ) : OP_IDLE;
         cmd_addr = addr;
      end else begin
         op       = last_op_q;
         cmd_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], idx_nx, ilv_q)};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q    <= '0;
         idx_q     <= '0;
         last_op_q <= OP_IDLE;
         ilv_q     <= 1'b0;
      end else if (clk_en) begin
         if (!adv) begin
            base_q    <= addr;
            idx_q     <= '0;
            last_op_q <= op;
            ilv_q     <= ilv;
         end else begin
            idx_q <= idx_nx;
         end
      end
   end

endmodule

// File: rtl/zt_write_pipe.sv
`timescale 1ns/1ps
module zt_write_pipe #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8,
   localparam int DW    = BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              in_wr,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [BYTES-1:0]  in_be,
   input  logic [DW-1:0]     wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DW-1:0]     arr_word,
   output logic              cm_en,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [BYTES-1:0]  cm_be,
   output logic [DW-1:0]     cm_data,
   output logic [DW-1:0]     fwd_word
);

   // stage one: data is on the wdata pins now; stage two: data registered
   logic              s1_v, s2_v;
   logic [ADDR_W-1:0] s1_a, s2_a;
   logic [BYTES-1:0]  s1_be, s2_be;
   logic [DW-1:0]     wd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
         s2_v <= 1'b0;
      end else if (clk_en) begin
         s1_v <= in_wr;
         s2_v <= s1_v;
      end
   end

   always_ff @(posedge clk) begin
      if (clk_en) begin
         s1_a  <= in_addr;
         s1_be <= in_be;
         s2_a  <= s1_a;
         s2_be <= s1_be;
         wd_q  <= wdata;
      end
   end

   assign cm_en   = s2_v;
   assign cm_addr = s2_a;
   assign cm_be   = s2_be;
   assign cm_data = wd_q;

   logic hit1, hit2;
   assign hit1 = s1_v && (s1_a == rd_addr);
   assign hit2 = s2_v && (s2_a == rd_addr);

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      always_comb begin
         if (hit1 && s1_be[b])
            fwd_word[b*BYTE_W +: BYTE_W] = wdata[b*BYTE_W +: BYTE_W];
         else if (hit2 && s2_be[b])
            fwd_word[b*BYTE_W +: BYTE_W] = wd_q[b*BYTE_W +: BYTE_W];
         else
            fwd_word[b*BYTE_W +: BYTE_W] = arr_word[b*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/zt_array.sv
`timescale 1ns/1ps
module zt_array #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8,
   localparam int DW    = BYTES * BYTE_W,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [BYTES-1:0]  wbe,
   input  logic [DW-1:0]     wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DW-1:0]     rword
);

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wbe[b])
            lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
      end

      assign rword[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
   end

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
   import zt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8,
   localparam int DW    = BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              adv,
   input  logic              wr,
   input  logic [BYTES-1:0]  be,
   input  logic              interleave,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic              out_en,
   output logic [DW-1:0]     rdata,
   output logic              rd_valid,
   output logic              rdata_oe
);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("zt_sram: ADDR_W must be at least 3");
   end
   if (BYTES < 1 || BYTE_W < 1) begin : g_bad_width
      $error("zt_sram: BYTES and BYTE_W must be positive");
   end

   logic              selected;
   zt_op_e            cmd_op;
   logic [ADDR_W-1:0] cmd_addr;
   logic [BYTES-1:0]  cmd_be;

   assign selected = !sel_a_n && sel_b && !sel_c_n;

   zt_burst_addr #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en   (clk_en),
      .adv      (adv),
      .selected (selected),
      .wr       (wr),
      .ilv      (interleave),
      .addr     (addr),
      .be       (be),
      .op       (cmd_op),
      .cmd_addr (cmd_addr),
      .cmd_be   (cmd_be)
   );

   // input register
   zt_op_e            c0_op;
   logic [ADDR_W-1:0] c0_addr;
   logic [BYTES-1:0]  c0_be;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c0_op <= OP_IDLE;
      end else if (clk_en) begin
         c0_op <= cmd_op;
      end
   end

   always_ff @(posedge clk) begin
      if (clk_en) begin
         c0_addr <= cmd_addr;
         c0_be   <= cmd_be;
      end
   end

   logic              cm_en;
   logic [ADDR_W-1:0] cm_addr;
   logic [BYTES-1:0]  cm_be;
   logic [DW-1:0]     cm_data;
   logic [DW-1:0]     arr_word;
   logic [DW-1:0]     fwd_word;

   zt_write_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_wpipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en   (clk_en),
      .in_wr    (c0_op == OP_WRITE),
      .in_addr  (c0_addr),
      .in_be    (c0_be),
      .wdata    (wdata),
      .rd_addr  (c0_addr),
      .arr_word (arr_word),
      .cm_en    (cm_en),
      .cm_addr  (cm_addr),
      .cm_be    (cm_be),
      .cm_data  (cm_data),
      .fwd_word (fwd_word)
   );

   zt_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_arr (
      .clk   (clk),
      .we    (cm_en && clk_en),
      .waddr (cm_addr),
      .wbe   (cm_be),
      .wdata (cm_data),
      .raddr (c0_addr),
      .rword (arr_word)
   );

   // output register
   logic [DW-1:0] rdata_q;
   logic          drive_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         rdata_q <= '0;
      end else if (clk_en) begin
         drive_q <= (c0_op == OP_READ);
         if (c0_op == OP_READ)
            rdata_q <= fwd_word;
      end
   end

   assign rdata    = rdata_q;
   assign rd_valid = drive_q;
   assign rdata_oe = drive_q & out_en;

endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk
   import zt_pkg::*;
#(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clk_en,
   input logic          sel_a_n,
   input logic          sel_b,
   input logic          sel_c_n,
   input logic          adv,
   input logic          wr,
   input logic          out_en,
   input logic [DW-1:0] rdata,
   input logic          rd_valid,
   input logic          rdata_oe
);

   // command type seen at the pins, tracked on enabled edges
   zt_op_e load_op_q, k1_q, k2_q;
   zt_op_e now_op;

   always_comb begin
      if (adv)
         now_op = load_op_q;
      else if (!sel_a_n && sel_b && !sel_c_n)
         now_op = wr ? OP_WRITE : OP_READ;
      else
         now_op = OP_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_op_q <= OP_IDLE;
         k1_q      <= OP_IDLE;
         k2_q      <= OP_IDLE;
      end else if (clk_en) begin
         if (!adv) load_op_q <= now_op;
         k1_q <= now_op;
         k2_q <= k1_q;
      end
   end

   assert_read_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (k2_q == OP_READ) |-> rd_valid);

   assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(rdata) && $stable(rd_valid)));

   assert_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (k2_q == OP_IDLE) |-> !rd_valid);

   assert_no_drive_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (k2_q == OP_WRITE) |-> (!rd_valid && !rdata_oe));

   assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (out_en && rd_valid));

   assert_reset_R12: assert property (@(posedge clk)
      !rst_n |=> (!rd_valid && !rdata_oe));

endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_en   (clk_en),
   .sel_a_n  (sel_a_n),
   .sel_b    (sel_b),
   .sel_c_n  (sel_c_n),
   .adv      (adv),
   .wr       (wr),
   .out_en   (out_en),
   .rdata    (rdata),
   .rd_valid (rd_valid),
   .rdata_oe (rdata_oe)
);

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;

   localparam int AW = 8;
   localparam int NB = 4;
   localparam int BW = 8;
   localparam int DW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b1;
   logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic          adv = 1'b0, wr = 1'b0, interleave = 1'b0, out_en = 1'b1;
   logic [NB-1:0] be = '0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rd_valid, rdata_oe;

   always #2 clk = ~clk;   // 250 MHz

   zt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .adv(adv), .wr(wr), .be(be), .interleave(interleave),
      .addr(addr), .wdata(wdata), .out_en(out_en),
      .rdata(rdata), .rd_valid(rd_valid), .rdata_oe(rdata_oe)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   string cur_tag = "R4";

   // reference model: 0 idle, 1 read, 2 write
   logic [DW-1:0] ref_mem [int];
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_idx = '0;
   int            b_op = 0;
   bit            b_ilv = 1'b0;
   int            r1_op = 0;
   logic [DW-1:0] r1_data = '0;
   logic [DW-1:0] d1 = '0, d2 = '0;
   bit            exp_valid = 1'b0;
   int            exp_kind = 0;
   logic [DW-1:0] exp_data = '0;

   function automatic logic [1:0] lo_bits(logic [1:0] s, logic [1:0] i, bit ilv);
      return ilv ? (s ^ i) : (s + i);
   endfunction

   function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                           logic [NB-1:0] m);
      logic [DW-1:0] r = old_w;
      for (int b = 0; b < NB; b++)
         if (m[b]) r[b*BW +: BW] = new_w[b*BW +: BW];
      return r;
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model at posedge, check at next negedge
   // desel: 0 selected, 1..3 breaks sel_a_n, sel_b, sel_c_n
   task automatic step(bit ce, int desel, bit adv_i, bit wr_i, logic [NB-1:0] be_i,
                       bit ilv_i, logic [AW-1:0] a_i, logic [DW-1:0] wd_new, bit oe_i);
      int            op;
      logic [AW-1:0] ea;
      logic [DW-1:0] rd;
      clk_en     = ce;
      sel_a_n    = (desel == 1);
      sel_b      = (desel != 2);
      sel_c_n    = (desel == 3);
      adv        = adv_i;
      wr         = wr_i;
      be         = be_i;
      interleave = ilv_i;
      addr       = a_i;
      wdata      = d2;
      out_en     = oe_i;
      @(posedge clk);
      if (ce) begin
         if (!adv_i) begin
            op = (desel == 0) ? (wr_i ? 2 : 1) : 0;
            ea = a_i;
            b_base = a_i; b_idx = 2'd0; b_op = op; b_ilv = ilv_i;
         end else begin
            op = b_op;
            b_idx = b_idx + 2'd1;
            ea = {b_base[AW-1:2], lo_bits(b_base[1:0], b_idx, b_ilv)};
         end
         rd = '0;
         if (op == 2)
            ref_mem[int'(ea)] = merge(ref_mem.exists(int'(ea)) ? ref_mem[int'(ea)] : '0,
                                      wd_new, be_i);
         if (op == 1) rd = ref_mem.exists(int'(ea)) ? ref_mem[int'(ea)] : '0;
         exp_valid = (r1_op == 1);
         exp_kind  = r1_op;
         if (r1_op == 1) exp_data = r1_data;
         r1_op = op; r1_data = rd;
         d2 = d1; d1 = wd_new;
      end
      @(negedge clk);
      chk(rd_valid == exp_valid,
          exp_kind == 1 ? "R1" : (exp_kind == 2 ? "R7" : "R6"),
          "rd_valid", {31'd0, rd_valid}, {31'd0, exp_valid});
      if (exp_valid)
         chk(rdata === exp_data, cur_tag, "rdata", rdata, exp_data);
      chk(rdata_oe == (exp_valid && oe_i), "R8", "rdata_oe",
          {31'd0, rdata_oe}, {31'd0, exp_valid && oe_i});
   endtask

   task automatic wr_cmd(logic [AW-1:0] a, logic [DW-1:0] d, logic [NB-1:0] m);
      step(1, 0, 0, 1, m, 0, a, d, 1);
   endtask
   task automatic rd_cmd(logic [AW-1:0] a);
      step(1, 0, 0, 0, '0, 0, a, $urandom, 1);
   endtask
   task automatic idle_cmd();
      step(1, 1, 0, 0, '0, 0, '0, $urandom, 1);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      // R12: reset clears the drive even with clk_en low
      clk_en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!rd_valid && !rdata_oe, "R12", "reset drive",
             {30'd0, rd_valid, rdata_oe}, '0);
      end
      rst_n = 1'b1;

      // R2: fill every word, then partial masks
      cur_tag = "R2";
      for (int a = 0; a < (1 << AW); a++)
         wr_cmd(a[AW-1:0], 32'h5a00_0000 ^ (a * 32'h0101_0101), 4'hf);
      wr_cmd(8'd5, 32'hdead_beef, 4'b0101);
      idle_cmd(); idle_cmd(); idle_cmd();
      rd_cmd(8'd5);
      wr_cmd(8'd6, 32'h1234_5678, 4'b0000);
      idle_cmd(); idle_cmd(); idle_cmd();
      rd_cmd(8'd6);
      idle_cmd(); idle_cmd();

      // R3: forwarding from both stages, newest wins
      cur_tag = "R3";
      wr_cmd(8'd10, 32'haaaa_0001, 4'hf);
      rd_cmd(8'd10);
      wr_cmd(8'd11, 32'h1111_1111, 4'b0011);
      wr_cmd(8'd11, 32'h2222_2222, 4'b0110);
      rd_cmd(8'd11);
      wr_cmd(8'd12, 32'hcafe_f00d, 4'b1001);
      rd_cmd(8'd13);
      rd_cmd(8'd12);
      idle_cmd(); idle_cmd();

      // R9: linear burst from low bits 2
      cur_tag = "R9";
      step(1, 0, 0, 0, '0, 0, 8'd42, 0, 1);
      for (int i = 0; i < 4; i++) step(1, 2, 1, 1, '0, 1, 8'd0, 0, 1);
      // R10: interleaved burst from low bits 1
      cur_tag = "R10";
      step(1, 0, 0, 0, '0, 1, 8'd77, 0, 1);
      for (int i = 0; i < 3; i++) step(1, 0, 1, 1, '0, 0, 8'd0, 0, 1);
      // R11: write burst ignores wr on advance; deselect burst stays idle
      cur_tag = "R11";
      step(1, 0, 0, 1, 4'hf, 0, 8'd90, 32'h0bad_0000, 1);
      for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 4'b1100, 0, 8'd0, 32'h7700_0000 + i, 1);
      step(1, 3, 0, 0, '0, 0, 8'd90, 0, 1);
      step(1, 0, 1, 0, '0, 0, 8'd0, 0, 1);
      for (int i = 0; i < 4; i++) rd_cmd(8'd88 + i[AW-1:0]);
      idle_cmd(); idle_cmd();

      // R6: each chip select alone blocks a read
      for (int s = 1; s < 4; s++) step(1, s, 0, 0, '0, 0, 8'd5, 0, 1);
      idle_cmd();

      // R5: stall in the middle of pending writes and reads
      cur_tag = "R5";
      wr_cmd(8'd20, 32'h2020_2020, 4'hf);
      rd_cmd(8'd20);
      step(0, 0, 0, 1, 4'hf, 0, 8'd20, 32'hffff_ffff, 1);
      step(0, 1, 0, 0, '0, 0, 8'd3, 0, 0);
      rd_cmd(8'd20);
      step(0, 0, 0, 0, '0, 0, 8'd1, 0, 1);
      idle_cmd(); idle_cmd();

      // R4 and R8: random mixed traffic on a small window of addresses
      cur_tag = "R4";
      for (int n = 0; n < 4000; n++) begin
         bit ce_r  = ($urandom % 10) != 0;
         int ds_r  = (($urandom % 10) == 0) ? 1 + ($urandom % 3) : 0;
         bit adv_r = ($urandom % 10) < 3;
         bit oe_r  = ($urandom % 10) != 0;
         step(ce_r, ds_r, adv_r, $urandom % 2, NB'($urandom), $urandom % 2,
              AW'($urandom % 24), $urandom, oe_r);
      end
      idle_cmd(); idle_cmd();

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule